// File: doc/BRIEF.md
# Timer and Watchdog with a Shared Prescaler

This block holds an 8-bit free-running counter and a watchdog. One 8-bit prescaler is shared between them, and a configuration byte decides which of the two gets it. The counter can step on the instruction-cycle enable or on edges of an external input pin. That pin is synchronised and edge-detected inside the block. The counter can also be loaded through a write port. The watchdog counts instruction cycles against a base period set by a parameter. It emits a one-clock timeout pulse each time its period runs out, and a clear strobe restarts it.

The configuration byte comes from a register that sits outside the block. That register is expected to reset to 0xFF. The block does not raise interrupts. It does not model the oscillator or any sleep behaviour. The parameter `WDT_BASE` must be at least 2.

Top module: `tmr_wdt_unit`

## Requirements
- R1: After reset, `tmrCount` is 0x00 and `wdtTimeout` is low.
- R2: With configuration bit 5 at 0, the counter source is the instruction-cycle enable. Each clock with `cycEn` high is one source tick.
- R3: With bit 5 at 1, the source is `extPin`, passed through two flip-flops. Bit 4 at 0 selects rising edges and bit 4 at 1 selects falling edges. Each detected edge is one source tick. The resulting count is visible three clocks after the pin changes.
- R4: With bit 3 at 0, the prescaler serves the counter. Rate code n in bits 2:0 makes the counter advance once per 2^(n+1) source ticks.
- R5: With bit 3 at 1, the counter advances on every source tick. The prescaler serves the watchdog, so a timeout occurs every `WDT_BASE`·2^n instruction cycles. With bit 3 at 0, a timeout occurs every `WDT_BASE` instruction cycles.
- R6: When `tmrWrEn` is high, `tmrWrData` is loaded into the counter and the prescaler is cleared. Source ticks are then ignored until two further instruction cycles have passed.
- R7: The counter wraps from 0xFF to 0x00 and gives no other indication that it wrapped.
- R8: `wdtClr` restarts the watchdog base period. When bit 3 is 1 it also clears the prescaler. When bit 3 is 0, the counter's progress is unaffected.
- R9: `wdtTimeout` is high for exactly one clock, on the clock after the instruction cycle that ends the period.
- R10: Configuration bits 7:6 have no effect. With 0xFF, the counter counts falling edges of `extPin` one for one, and the watchdog uses the 1:128 ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cycEn | input | 1 | Instruction-cycle enable, high for one clock per instruction cycle |
| extPin | input | 1 | External count input, asynchronous |
| cfgByte | input | 8 | Configuration: [5] source, [4] edge, [3] prescaler owner, [2:0] rate |
| tmrWrEn | input | 1 | Counter write strobe |
| tmrWrData | input | 8 | Value loaded on a write |
| wdtClr | input | 1 | Watchdog clear strobe |
| tmrCount | output | 8 | Current counter value |
| wdtTimeout | output | 1 | One-clock watchdog timeout pulse |

## Verification
The bench builds the block with `WDT_BASE` set to 4. This makes a timeout at the largest ratio take only 512 instruction cycles. As a result, both prescaler owners, the full range of rate codes, timeouts racing against clears and counter wrap all occur many times within a short run. The cycle-accurate model also follows write-hold windows that overlap edges and timeouts during a random phase in which the configuration keeps changing.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef struct packed {
    logic tmrLoad;    // load counter from write port
    logic preClr;     // clear the shared prescaler
    logic preStep;    // one input tick for the prescaler
    logic preForTmr;  // prescaler owned by the counter
    logic tmrBypass;  // counter step without prescaler
    logic wdtBypass;  // watchdog period end without prescaler
  } tmrStrobe_t;
endpackage

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int WDT_BASE = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycEn,
  input  logic       extPin,
  input  logic       extSel,
  input  logic       fallSel,
  input  logic       preToWdt,
  input  logic       tmrWrEn,
  input  logic       wdtClr,
  output tmrStrobe_t strobe
);
  localparam int BW = (WDT_BASE > 1) ? $clog2(WDT_BASE) : 1;
  localparam logic [BW-1:0] BASE_LAST = BW'(WDT_BASE - 1);

  logic [2:0]    syncQ;   // [0],[1] synchroniser, [2] previous level
  logic [1:0]    holdQ;
  logic [BW-1:0] baseQ;
  logic riseDet, fallDet, srcTick, srcOk, baseEnd, baseTick;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[1:0], extPin};
  end

  assign riseDet  = syncQ[1] & ~syncQ[2];
  assign fallDet  = ~syncQ[1] & syncQ[2];
  assign srcTick  = extSel ? (fallSel ? fallDet : riseDet) : cycEn;
  assign srcOk    = srcTick & (holdQ == 2'd0) & ~tmrWrEn;
  assign baseEnd  = cycEn & (baseQ == BASE_LAST);
  assign baseTick = baseEnd & ~wdtClr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                        holdQ <= '0;
    else if (tmrWrEn)                 holdQ <= 2'd2;
    else if (cycEn && holdQ != 2'd0)  holdQ <= holdQ - 2'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       baseQ <= '0;
    else if (wdtClr) baseQ <= '0;
    else if (cycEn)  baseQ <= baseEnd ? '0 : baseQ + 1'b1;
  end

  always_comb begin
    strobe.tmrLoad   = tmrWrEn;
    strobe.preClr    = tmrWrEn | (wdtClr & preToWdt);
    strobe.preForTmr = ~preToWdt;
    strobe.preStep   = preToWdt ? baseTick : srcOk;
    strobe.tmrBypass = preToWdt & srcOk;
    strobe.wdtBypass = ~preToWdt & baseTick;
  end

  assert_hold_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (holdQ != 2'd0) |-> !(strobe.tmrBypass || (strobe.preStep && strobe.preForTmr)));

  assert_base_restart_R8: assert property (@(posedge clk) disable iff (!rstN)
    wdtClr |=> (baseQ == '0));
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] rate,
  input  tmrStrobe_t strobe,
  input  logic [7:0] wrData,
  output logic [7:0] tmrCount,
  output logic       wdtTimeout
);
  logic [7:0] preQ, tmrQ, thr;
  logic [8:0] span;
  logic preOut, tmrInc, toEvt;

  assign span   = strobe.preForTmr ? (9'd2 << rate) : (9'd1 << rate);
  assign thr    = span[7:0] - 8'd1;
  assign preOut = strobe.preStep & ~strobe.preClr & (preQ >= thr);
  assign tmrInc = strobe.tmrBypass | (preOut & strobe.preForTmr);
  assign toEvt  = strobe.wdtBypass | (preOut & ~strobe.preForTmr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                preQ <= '0;
    else if (strobe.preClr)   preQ <= '0;
    else if (preOut)          preQ <= '0;
    else if (strobe.preStep)  preQ <= preQ + 8'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               tmrQ <= '0;
    else if (strobe.tmrLoad) tmrQ <= wrData;
    else if (tmrInc)         tmrQ <= tmrQ + 8'd1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wdtTimeout <= 1'b0;
    else       wdtTimeout <= toEvt;
  end

  assign tmrCount = tmrQ;

  assert_load_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.tmrLoad |=> (tmrCount == $past(wrData)));

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rstN)
    (tmrCount == 8'hFF && tmrInc && !strobe.tmrLoad) |=> (tmrCount == 8'h00));

  assert_pre_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe.preClr |=> (preQ == 8'h00));

  assert_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    wdtTimeout |=> !wdtTimeout);
endmodule

// File: rtl/tmr_wdt_unit.sv
module tmr_wdt_unit
  import tmr_pkg::*;
#(
  parameter int WDT_BASE = 256
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cycEn,
  input  logic       extPin,
  input  logic [7:0] cfgByte,
  input  logic       tmrWrEn,
  input  logic [7:0] tmrWrData,
  input  logic       wdtClr,
  output logic [7:0] tmrCount,
  output logic       wdtTimeout
);
  tmrStrobe_t strobe;

  tmr_ctrl #(.WDT_BASE(WDT_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .extPin(extPin),
    .extSel(cfgByte[5]), .fallSel(cfgByte[4]), .preToWdt(cfgByte[3]),
    .tmrWrEn(tmrWrEn), .wdtClr(wdtClr), .strobe(strobe)
  );

  tmr_datapath u_dp (
    .clk(clk), .rstN(rstN), .rate(cfgByte[2:0]), .strobe(strobe),
    .wrData(tmrWrData), .tmrCount(tmrCount), .wdtTimeout(wdtTimeout)
  );
endmodule

// File: tb/tmr_wdt_unit_bench.sv
`timescale 1ns/100ps
module tmr_wdt_unit_bench;
  localparam int WB = 4;
  logic clk = 0, rstN = 0, cycEn = 0, extPin = 0, tmrWrEn = 0, wdtClr = 0;
  logic [7:0] cfgByte = 8'hFF, tmrWrData = 0;
  logic [7:0] tmrCount;
  logic wdtTimeout;
  int checks = 0, failures = 0, clocks = 0, divCnt = 0, toCount = 0, doublePulse = 0;
  bit autoCyc = 1, prevTo = 0, done = 0;
  // reference model state
  int s1 = 0, s2 = 0, s3 = 0, mHold = 0, mBase = 0, mPre = 0, mTmr = 0, mTo = 0;

  always #2.5 clk = ~clk;

  tmr_wdt_unit #(.WDT_BASE(WB)) u_tmr_wdt_unit (
    .clk(clk), .rstN(rstN), .cycEn(cycEn), .extPin(extPin), .cfgByte(cfgByte),
    .tmrWrEn(tmrWrEn), .tmrWrData(tmrWrData), .wdtClr(wdtClr),
    .tmrCount(tmrCount), .wdtTimeout(wdtTimeout)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural model, evaluated with the inputs present at each edge
  always @(posedge clk) begin
    if (!rstN) begin
      s1 = 0; s2 = 0; s3 = 0; mHold = 0; mBase = 0; mPre = 0; mTmr = 0; mTo = 0;
    end else begin
      int rise, fall, src, ok, bt, step, thr, pclr, pout, inc, to, psa, rate;
      rise = (s2 == 1 && s3 == 0); fall = (s2 == 0 && s3 == 1);
      s3 = s2; s2 = s1; s1 = extPin;
      psa = cfgByte[3]; rate = cfgByte[2:0];
      src = cfgByte[5] ? (cfgByte[4] ? fall : rise) : cycEn;
      ok = src && mHold == 0 && !tmrWrEn;
      bt = cycEn && mBase == WB - 1 && !wdtClr;
      if (wdtClr) mBase = 0;
      else if (cycEn) mBase = (mBase == WB - 1) ? 0 : mBase + 1;
      if (tmrWrEn) mHold = 2;
      else if (cycEn && mHold > 0) mHold--;
      step = psa ? bt : ok;
      thr = psa ? (1 << rate) - 1 : (2 << rate) - 1;
      pclr = tmrWrEn || (wdtClr && psa);
      pout = step && !pclr && mPre >= thr;
      if (pclr || pout) mPre = 0;
      else if (step) mPre = (mPre + 1) % 256;
      inc = psa ? ok : pout;
      to = psa ? pout : bt;
      if (tmrWrEn) mTmr = tmrWrData;
      else if (inc) mTmr = (mTmr + 1) % 256;
      mTo = to;
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(cfgByte[3] ? "R5" : (cfgByte[5] ? "R3" : "R4"), tmrCount, mTmr);
      chk("R9", wdtTimeout, mTo);
      if (wdtTimeout) toCount++;
      if (wdtTimeout && prevTo) doublePulse++;
      prevTo = wdtTimeout;
    end
  end

  always @(posedge clk) begin
    clocks++;
    if (clocks > 150000 && !done) begin
      done = 1;
      failures++; checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", clocks, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic step(bit wr = 0, logic [7:0] d = 0, bit clr = 0);
    @(negedge clk); #0.5;
    if (autoCyc) begin cycEn = (divCnt == 3); divCnt = (divCnt + 1) % 4; end
    tmrWrEn = wr; tmrWrData = d; wdtClr = clr;
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulses(int n);
    for (int i = 0; i < n; i++) begin
      extPin = ~extPin; run(6);
      extPin = ~extPin; run(6);
    end
  endtask

  task automatic waitCyc(int n);
    int seen = 0;
    while (seen < n) begin step(); if (cycEn) seen++; end
  endtask

  initial begin
    run(3);
    chk("R1", tmrCount, 0); chk("R1", wdtTimeout, 0);
    @(negedge clk); #0.5 rstN = 1;
    chk("R1", tmrCount, 0);
    // default configuration: falling edges, watchdog owns prescaler
    extPin = 1; run(8);
    step(1, 8'h00); run(12);
    pulses(7); run(6);
    chk("R10", tmrCount, 7);
    cfgByte = 8'h3F; step(1, 8'h00); run(12);
    pulses(5); run(6);
    chk("R10", tmrCount, 5);
    toCount = 0; step(0, 0, 1); run(WB * 128 * 4 * 2 + 8);
    chk("R10", toCount, 2);
    // rising edges, prescaler on watchdog
    extPin = 0; cfgByte = 8'h28; run(8);
    step(1, 8'h10); run(12);
    pulses(9); run(6);
    chk("R3", tmrCount, 8'h19);
    // instruction-cycle source, prescaler on counter
    cfgByte = 8'h00; step(1, 8'h00); waitCyc(2);
    chk("R6", tmrCount, 0);
    waitCyc(20); run(2);
    chk("R4", tmrCount, 10);
    cfgByte = 8'h03; step(1, 8'h00); waitCyc(2 + 64); run(2);
    chk("R4", tmrCount, 4);
    // instruction-cycle source, direct counting, write hold and wrap
    cfgByte = 8'h08; step(1, 8'hFD); waitCyc(2); run(2);
    chk("R6", tmrCount, 8'hFD);
    waitCyc(1); run(2);
    chk("R2", tmrCount, 8'hFE);
    waitCyc(2); run(2);
    chk("R7", tmrCount, 8'h00);
    // watchdog timing with rate 2
    cfgByte = 8'h0A; step(0, 0, 1); toCount = 0; run(640 + 8);
    chk("R5", toCount, 10);
    cfgByte = 8'h00; step(0, 0, 1); toCount = 0; run(WB * 4 * 5 + 4);
    chk("R5", toCount, 5);
    // repeated clears keep the watchdog quiet
    cfgByte = 8'h08; toCount = 0;
    for (int i = 0; i < 40; i++) begin step(0, 0, 1); run(10); end
    chk("R8", toCount, 0);
    // clears do not disturb a counter-owned prescaler
    cfgByte = 8'h01; step(1, 8'h00); waitCyc(2);
    for (int i = 0; i < 10; i++) begin step(0, 0, 1); waitCyc(4); end
    run(2);
    chk("R8", tmrCount, 10);
    // random phase against the model
    for (int i = 0; i < 6000; i++) begin
      @(negedge clk); #0.5;
      autoCyc = 0;
      if (i % 300 == 0) cfgByte = 8'($urandom);
      cycEn = ($urandom % 4 == 0);
      if ($urandom % 5 == 0) extPin = ~extPin;
      tmrWrEn = ($urandom % 97 == 0); tmrWrData = 8'($urandom);
      wdtClr = ($urandom % 53 == 0);
    end
    @(negedge clk); #0.5 tmrWrEn = 0; wdtClr = 0; cycEn = 0;
    run(2);
    chk("R9", doublePulse, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule